// File: doc/BRIEF.md
# Mixed-Resolution PWM Bank

This block holds five pulse-width modulators that all run from the system clock. Two channels have 13-bit resolution and a fixed period of 8192 clocks. Two have 10-bit resolution and a fixed period of 1024 clocks. The fifth has 8-bit resolution. Its count advances once every `step` clocks, and software chooses the step so that the period is 1024, 8192, 16384 or 32768 clocks. The 13-bit and 10-bit channels share one free-running timebase. The 8-bit channel has its own prescaler and counter.

Software writes duty values and the 8-bit period code through a single write port. Every duty register is double-buffered. A write goes into a shadow register, and the comparator takes the new value only when its counter wraps. A running period therefore never mixes an old and a new duty. The 8-bit channel holds a small controller with two states. In `ST_RUN` no period change is waiting. A write of a code that differs from the active one captures the code and moves to `ST_PEND`. In `ST_PEND`, a further write replaces the waiting code. At the next wrap of the 8-bit counter the waiting code becomes active and the prescaler restarts. The controller then returns to `ST_RUN`, or stays in `ST_PEND` if a different code was written in that same wrap cycle.

Top module: `pwm_bank`

## Requirements
- R1: After reset all five outputs are low, every duty value is 0, and the 8-bit channel uses period code 0.
- R2: Each 13-bit channel repeats every 8192 clocks and is high for `duty` consecutive clocks at the start of each period. Duty 8191 leaves exactly one low clock per period.
- R3: Each 10-bit channel repeats every 1024 clocks and is high for `duty` clocks per period.
- R4: The 8-bit channel advances once every `step` clocks and is high for `duty*step` clocks per period of `256*step` clocks. Period codes 0, 1, 2 and 3 select steps of 4, 32, 64 and 128.
- R5: A duty of 0 holds the output low for the whole period.
- R6: A duty write goes to a shadow register and reaches the comparator only when that channel's counter wraps. The period running at the time of the write completes with the old duty.
- R7: The write addresses are: 0 and 1 for the 13-bit channels, 2 and 3 for the 10-bit channels, 4 for the 8-bit duty, and 5 for the period code in `wr_data[1:0]`. Narrower channels take the low bits of `wr_data`. Writes to addresses 6 and 7 change nothing.
- R8: A period-code change takes effect only at the next wrap of the 8-bit counter. The current period finishes at its old length, and the prescaler and counter then restart from zero under the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Register select (see R7) |
| wr_data | input | 13 | Write data |
| pwm_out | output | 5 | Bit 0-1: 13-bit, bit 2-3: 10-bit, bit 4: 8-bit channel |

## Verification
The hardest case to reach from the ports is a period-code write that lands inside a running 8-bit period. The check has to show that the old period still completes at its old length and that only the next period is stretched. The only external reference for period position is the output itself. The stimulus therefore waits for a rising edge of the 8-bit output, writes a new code a few clocks later, and measures the distance to the following two rising edges. The same edge-aligned method places a duty write in the middle of a 13-bit period to show that the shadow register holds it back.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int WIDE_W   = 13;
    localparam int MID_W    = 10;
    localparam int NARROW_W = 8;
    localparam int N_WIDE   = 2;
    localparam int N_MID    = 2;
    localparam int N_CH     = N_WIDE + N_MID + 1;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = WIDE_W;
    localparam int SEL_W    = 2;
    localparam int PRE_W    = 7;

    localparam logic [ADDR_W-1:0] A_MID0   = ADDR_W'(N_WIDE);
    localparam logic [ADDR_W-1:0] A_NARROW = ADDR_W'(N_WIDE + N_MID);
    localparam logic [ADDR_W-1:0] A_PERSEL = ADDR_W'(N_WIDE + N_MID + 1);

    typedef enum logic [SEL_W-1:0] {
        PER_1K  = 2'd0,
        PER_8K  = 2'd1,
        PER_16K = 2'd2,
        PER_32K = 2'd3
    } per_sel_e;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_PEND = 1'b1
    } sel_state_e;

    // last prescaler value of one count step (step length minus one)
    function automatic logic [PRE_W-1:0] step_last(input logic [SEL_W-1:0] s);
        logic [PRE_W-1:0] r;
        unique case (s)
            2'd0:    r = PRE_W'(3);
            2'd1:    r = PRE_W'(31);
            2'd2:    r = PRE_W'(63);
            default: r = PRE_W'(127);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int HI_W = 13,
    parameter int LO_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [HI_W-1:0] count,
    output logic            wrap_hi,
    output logic            wrap_lo
);
    logic [HI_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign count   = cnt_q;
    assign wrap_hi = &cnt_q;
    assign wrap_lo = &cnt_q[LO_W-1:0];
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] count,
    input  logic         wrap,
    output logic         pwm
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (wr_en) shadow_q <= wr_data;
            if (wrap)  act_q    <= shadow_q;
        end
    end

    assign pwm = (count < act_q);
endmodule

// File: rtl/pwm_var_chan.sv
module pwm_var_chan
    import pwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                duty_wr,
    input  logic [NARROW_W-1:0] duty_data,
    input  logic                sel_wr,
    input  logic [SEL_W-1:0]    sel_data,
    output logic                pwm
);
    sel_state_e          state_q, state_d;
    logic [SEL_W-1:0]    cur_sel, pend_sel;
    logic [PRE_W-1:0]    presc_q;
    logic [NARROW_W-1:0] cnt_q;
    logic [NARROW_W-1:0] shadow_q, act_q;
    logic                tick, wrap;
    logic                capture, apply;

    assign tick = (presc_q == step_last(cur_sel));
    assign wrap = tick && (&cnt_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        apply   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (sel_wr && (sel_data != cur_sel)) begin
                    capture = 1'b1;
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (wrap) begin
                    apply = 1'b1;
                    if (sel_wr && (sel_data != pend_sel)) begin
                        capture = 1'b1;
                        state_d = ST_PEND;
                    end else begin
                        state_d = ST_RUN;
                    end
                end else if (sel_wr) begin
                    capture = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sel  <= PER_1K;
            pend_sel <= PER_1K;
            presc_q  <= '0;
            cnt_q    <= '0;
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (capture) pend_sel <= sel_data;
            if (apply)   cur_sel  <= pend_sel;
            if (tick || apply) presc_q <= '0;
            else               presc_q <= presc_q + 1'b1;
            if (apply)     cnt_q <= '0;
            else if (tick) cnt_q <= cnt_q + 1'b1;
            if (duty_wr) shadow_q <= duty_data;
            if (wrap)    act_q    <= shadow_q;
        end
    end

    assign pwm = (cnt_q < act_q);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_CH-1:0]   pwm_out
);
    logic [WIDE_W-1:0] tb_count;
    logic              tb_wrap_hi, tb_wrap_lo;

    pwm_timebase #(.HI_W(WIDE_W), .LO_W(MID_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (tb_count),
        .wrap_hi (tb_wrap_hi),
        .wrap_lo (tb_wrap_lo)
    );

    for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
        pwm_cmp_chan #(.W(WIDE_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_addr == ADDR_W'(i))),
            .wr_data (wr_data[WIDE_W-1:0]),
            .count   (tb_count),
            .wrap    (tb_wrap_hi),
            .pwm     (pwm_out[i])
        );
    end

    for (genvar j = 0; j < N_MID; j++) begin : g_mid
        pwm_cmp_chan #(.W(MID_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_addr == A_MID0 + ADDR_W'(j))),
            .wr_data (wr_data[MID_W-1:0]),
            .count   (tb_count[MID_W-1:0]),
            .wrap    (tb_wrap_lo),
            .pwm     (pwm_out[N_WIDE+j])
        );
    end

    pwm_var_chan u_var (
        .clk       (clk),
        .rst_n     (rst_n),
        .duty_wr   (wr_en && (wr_addr == A_NARROW)),
        .duty_data (wr_data[NARROW_W-1:0]),
        .sel_wr    (wr_en && (wr_addr == A_PERSEL)),
        .sel_data  (wr_data[SEL_W-1:0]),
        .pwm       (pwm_out[N_CH-1])
    );
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wrap10,
    input logic       var_tick,
    input logic       var_wrap,
    input logic [1:0] var_sel,
    input logic [7:0] var_act,
    input logic [7:0] var_cnt,
    input logic       narrow_out
);
    // R3: the 10-bit wrap never fires on two consecutive clocks
    p_wrap_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap10 |=> !wrap10);

    // R4: the 8-bit counter moves only on a prescaler step
    p_step_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !var_tick |=> $stable(var_cnt));

    // R8: the period code changes only at an 8-bit wrap
    p_sel_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !var_wrap |=> $stable(var_sel));

    // R8: after a wrap the counter restarts at zero
    p_cnt_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        var_wrap |=> (var_cnt == 8'd0));

    // R6: the duty in use changes only at a wrap
    p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !var_wrap |=> $stable(var_act));

    // R5: zero duty keeps the 8-bit output low
    p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (var_act == 8'd0) |-> !narrow_out);
endmodule

bind pwm_bank pwm_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrap10     (tb_wrap_lo),
    .var_tick   (u_var.tick),
    .var_wrap   (u_var.wrap),
    .var_sel    (u_var.cur_sel),
    .var_act    (u_var.act_q),
    .var_cnt    (u_var.cnt_q),
    .narrow_out (pwm_out[4])
);

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [12:0] wr_data = '0;
    logic [4:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    bit busy   = 1'b0;
    bit ended  = 1'b0;

    typedef struct {
        int    ch;
        int    hi;
        int    per;
        string req;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    pwm_bank u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 13'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_rise(input int ch, input int limit, output bit ok);
        bit prev;
        prev = pwm_out[ch];
        ok = 1'b0;
        for (int n = 0; n < limit; n++) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) begin
                ok = 1'b1;
                break;
            end
            prev = pwm_out[ch];
        end
    endtask

    // called right after a rise: counts high clocks until the next rise
    task automatic one_period(input int ch, input int limit, output int hi, output int per);
        hi  = 1;
        per = -1;
        for (int n = 1; n <= limit; n++) begin
            bit prev;
            prev = pwm_out[ch];
            @(negedge clk);
            if (!prev && pwm_out[ch]) begin
                per = n;
                break;
            end
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic expect_item(input int ch, input int hi, input int per, input string req);
        exp_t e;
        e.ch = ch; e.hi = hi; e.per = per; e.req = req;
        sbq.push_back(e);
        wait (sbq.size() == 0 && !busy);
    endtask

    // monitor: pops expectations and measures the output
    initial begin
        forever begin
            exp_t e;
            bit ok;
            int hi, per;
            wait (sbq.size() > 0);
            e = sbq.pop_front();
            busy = 1'b1;
            wait_rise(e.ch, 2 * e.per + 16, ok);
            if (!ok) begin
                check(e.req, "no rising edge", 0, 1);
            end else begin
                one_period(e.ch, e.per + 16, hi, per);
                check(e.req, $sformatf("ch%0d high clocks", e.ch), hi, e.hi);
                check(e.req, $sformatf("ch%0d period", e.ch), per, e.per);
            end
            busy = 1'b0;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ok;
        int hi, per, t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: outputs stay low after reset
        hi = 0;
        for (int n = 0; n < 1100; n++) begin
            @(negedge clk);
            if (pwm_out != 5'd0) hi++;
        end
        check("R1", "non-zero output clocks after reset", hi, 0);

        wr(0, 100);
        wr(1, 8191);
        wr(2, 1);
        wr(3, 1023);
        wr(4, 64);
        wr(6, 13'h1FFF);   // R7: ignored
        wr(7, 13'h0AAA);   // R7: ignored
        repeat (8300) @(negedge clk);

        expect_item(0, 100, 8192, "R2");
        expect_item(1, 8191, 8192, "R2");
        expect_item(2, 1, 1024, "R3");
        expect_item(3, 1023, 1024, "R7");
        expect_item(4, 256, 1024, "R4");

        // R6: a duty write in mid-period must not touch the running period
        wait_rise(0, 9000, ok);
        check("R6", "ch0 rise found", int'(ok), 1);
        hi = 1; per = -1;
        for (int n = 1; n <= 8300; n++) begin
            bit prev;
            prev = pwm_out[0];
            if (n == 4) begin
                wr_en = 1'b1; wr_addr = 3'd0; wr_data = 13'd4000;
            end else if (n == 5) begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            if (!prev && pwm_out[0]) begin
                per = n;
                break;
            end
            if (pwm_out[0]) hi++;
        end
        check("R6", "ch0 high in write period", hi, 100);
        check("R6", "ch0 write period length", per, 8192);
        expect_item(0, 4000, 8192, "R6");

        // R5: zero duty holds output low
        wr(2, 0);
        repeat (2100) @(negedge clk);
        hi = 0;
        for (int n = 0; n < 1024; n++) begin
            @(negedge clk);
            if (pwm_out[2]) hi++;
        end
        check("R5", "ch2 high clocks at duty 0", hi, 0);

        // R8: period change waits for the wrap
        wait_rise(4, 2100, ok);
        check("R8", "ch4 rise found", int'(ok), 1);
        t0 = 0;
        for (int n = 1; n <= 1100; n++) begin
            bit prev;
            prev = pwm_out[4];
            if (n == 3) begin
                wr_en = 1'b1; wr_addr = 3'd5; wr_data = 13'd1;
            end else if (n == 4) begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            if (!prev && pwm_out[4]) begin
                t0 = n;
                break;
            end
        end
        check("R8", "old period length after select write", t0, 1024);
        one_period(4, 8300, hi, per);
        check("R8", "first new period high", hi, 2048);
        check("R8", "first new period length", per, 8192);

        // R4: code 2 gives step 64
        wr(5, 2);
        repeat (8300) @(negedge clk);
        expect_item(4, 4096, 16384, "R4");

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule